// File: doc/BRIEF.md
# Two-Way Writeback Data Cache

This block sits between the memory stage of a pipelined core and a main memory that is one word wide. It keeps 256 sets of two ways. Each way holds one 32-bit word together with a tag, a valid flag and a dirty flag. Each set also has one replacement bit. The core presents a load or store with a size code in funct3 form and holds the request until the stall output falls. Hits are served in the same cycle. Stores mark the line dirty and do not reach memory until the line is evicted.

On a miss, a small controller takes over. If the chosen victim is dirty, the controller first writes it back to its rebuilt address. It then reads the wanted word and installs it. During install it sets the tag, the valid and dirty flags and the replacement bit. The retried request then hits. Sub-word loads pick the byte or halfword out of the cached word and extend it. Sub-word stores merge into the cached word.

Top module: `dcache2w`

## Requirements
- R1: A request whose tag matches a valid way in its set (address bits 31:10 tag, 9:2 set, 1:0 byte offset) completes with stall_o low in the cycle it is presented, and rdata_o carries the loaded value.
- R2: A miss on a set with no dirty victim holds stall_o high for exactly 3 cycles. It issues one memory read at {addr_i[31:2],2'b00}, and the retried access then returns the memory word.
- R3: A miss whose victim is valid and dirty first writes the victim word to memory at {victim tag, set, 2'b00}, then reads the new word. stall_o is high for exactly 4 cycles.
- R4: The victim is way 0 if invalid, else way 1 if invalid, else the way named by the set's replacement bit. Every hit and every install points that bit at the other way.
- R5: A store hit changes only the cache, sets the dirty flag and causes no memory traffic. Later loads see the new data.
- R6: A store miss allocates the line, merges the store into the fetched word and leaves the line dirty. Memory keeps the old value until eviction.
- R7: Load size codes: 000 signed byte, 001 signed halfword, 010 word, 100 unsigned byte, 101 unsigned halfword. The byte is chosen by addr_i[1:0] and the halfword by addr_i[1].
- R8: Store size codes: 000 replaces only the byte at addr_i[1:0], 001 replaces only the halfword at addr_i[1], 010 replaces the whole word.
- R9: rst_ni low (asynchronous) clears every valid flag and returns the controller to idle. With no request, stall_o and mem_req_o are low, and a line cached before reset misses afterwards.
- R10: The miss sequence is idle, optional writeback, fetch, install, idle. Memory is requested only in writeback (write) and fetch (read), and a clean miss performs no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until stall_o is low |
| we_i | input | 1 | 1 for store, 0 for load |
| size_i | input | 3 | funct3 size code |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Store data, right-aligned |
| rdata_o | output | 32 | Load result, valid when stall_o is low |
| stall_o | output | 1 | Core must hold while high |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write when high |
| mem_addr_o | output | 32 | Word-aligned memory address |
| mem_wdata_o | output | 32 | Evicted word |
| mem_rdata_i | input | 32 | Memory read data, one cycle after the read strobe |

## Verification
The bench fills one set with three tags so that a mistaken replacement choice shows up as a miss on the line that should have stayed. It forces a dirty eviction and checks the bus. A design that skipped the writeback would show 3 stall cycles instead of 4, and the memory word would stay stale. A design that wrote through on store hits would show an extra memory write. Byte and halfword stores at several offsets are followed by signed and unsigned loads, so a wrong merge lane or a wrong extension shows up as a wrong value. A reset in mid-run checks that lines cached earlier no longer hit.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WB    = 2'd1,
    ST_FETCH = 2'd2,
    ST_UPD   = 2'd3
  } dc_state_e;

  localparam logic [2:0] SZ_B  = 3'b000;
  localparam logic [2:0] SZ_H  = 3'b001;
  localparam logic [2:0] SZ_W  = 3'b010;
  localparam logic [2:0] SZ_BU = 3'b100;
  localparam logic [2:0] SZ_HU = 3'b101;
endpackage

// File: rtl/dcache_way.sv
module dcache_way
  import dcache_pkg::*;
#(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned TAG_W = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              valid_o,
  output logic              dirty_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [WORD_W-1:0] data_o,
  input  logic              wr_en_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              wr_dirty_i
);
  localparam int unsigned SETS = 1 << IDX_W;

  logic [SETS-1:0]   valid_q;
  logic [SETS-1:0]   dirty_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [WORD_W-1:0] data_q [SETS];

  // flags need reset, payload does not
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en_i) begin
      valid_q[idx_i] <= 1'b1;
      dirty_q[idx_i] <= wr_dirty_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[idx_i]  <= wr_tag_i;
      data_q[idx_i] <= wr_data_i;
    end
  end

  assign valid_o = valid_q[idx_i];
  assign dirty_o = dirty_q[idx_i];
  assign tag_o   = tag_q[idx_i];
  assign data_o  = data_q[idx_i];
endmodule

// File: rtl/dcache_lane.sv
module dcache_lane
  import dcache_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [2:0]        size_i,
  input  logic [1:0]        off_i,
  output logic [WORD_W-1:0] load_o,
  output logic [WORD_W-1:0] merged_o
);
  logic [7:0]  sel_b;
  logic [15:0] sel_h;

  assign sel_b = word_i[{off_i, 3'b000} +: 8];
  assign sel_h = word_i[{off_i[1], 4'b0000} +: 16];

  always_comb begin
    unique case (size_i)
      SZ_B:    load_o = {{24{sel_b[7]}}, sel_b};
      SZ_BU:   load_o = {24'b0, sel_b};
      SZ_H:    load_o = {{16{sel_h[15]}}, sel_h};
      SZ_HU:   load_o = {16'b0, sel_h};
      default: load_o = word_i;
    endcase
  end

  always_comb begin
    merged_o = word_i;
    unique case (size_i)
      SZ_B:    merged_o[{off_i, 3'b000} +: 8] = wdata_i[7:0];
      SZ_H:    merged_o[{off_i[1], 4'b0000} +: 16] = wdata_i[15:0];
      SZ_W:    merged_o = wdata_i;
      default: merged_o = wdata_i;
    endcase
  end
endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
  import dcache_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      req_i,
  input  logic      hit_i,
  input  logic      vdirty_i,
  input  logic      vway_i,
  output dc_state_e st_o,
  output logic      stall_o,
  output logic      vic_o
);
  dc_state_e st_q, st_d;
  logic      vic_q;
  logic      miss;

  assign miss = req_i && !hit_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (miss) st_d = vdirty_i ? ST_WB : ST_FETCH;
      ST_WB:    st_d = ST_FETCH;
      ST_FETCH: st_d = ST_UPD;
      ST_UPD:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      vic_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && miss) vic_q <= vway_i;
    end
  end

  assign st_o    = st_q;
  assign vic_o   = vic_q;
  assign stall_o = (st_q == ST_IDLE) ? miss : 1'b1;
endmodule

// File: rtl/dcache2w.sv
module dcache2w
  import dcache_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [2:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              stall_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i
);
  localparam int unsigned OFF_W = 2;
  localparam int unsigned TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int unsigned SETS  = 1 << IDX_W;
  localparam int unsigned WAYS  = 2;

  logic [TAG_W-1:0] tag;
  logic [IDX_W-1:0] idx;
  logic [OFF_W-1:0] off;

  assign tag = addr_i[ADDR_W-1 -: TAG_W];
  assign idx = addr_i[OFF_W +: IDX_W];
  assign off = addr_i[OFF_W-1:0];

  logic              w_valid [WAYS];
  logic              w_dirty [WAYS];
  logic [TAG_W-1:0]  w_tag   [WAYS];
  logic [WORD_W-1:0] w_data  [WAYS];
  logic [WAYS-1:0]   hit_w;
  logic [WAYS-1:0]   way_we;

  dc_state_e   st;
  logic        vic_q;
  logic        hit, hit_way, vway, vdirty;
  logic        acc_hit, upd;
  logic [WORD_W-1:0] base_word, load_word, merged_word, wr_word;
  logic [SETS-1:0]   lru_q;

  assign upd     = (st == ST_UPD);
  assign acc_hit = (st == ST_IDLE) && req_i && hit;
  assign wr_word = (upd && !we_i) ? mem_rdata_i : merged_word;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_w[w]  = w_valid[w] && (w_tag[w] == tag);
    assign way_we[w] = (acc_hit && we_i && hit_w[w]) || (upd && vic_q == 1'(w));

    dcache_way #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_way (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .idx_i      (idx),
      .valid_o    (w_valid[w]),
      .dirty_o    (w_dirty[w]),
      .tag_o      (w_tag[w]),
      .data_o     (w_data[w]),
      .wr_en_i    (way_we[w]),
      .wr_tag_i   (tag),
      .wr_data_i  (wr_word),
      .wr_dirty_i (upd ? we_i : 1'b1)
    );
  end

  assign hit     = |hit_w;
  assign hit_way = hit_w[1];

  // fill invalid ways before consulting the replacement bit
  assign vway   = !w_valid[0] ? 1'b0 : (!w_valid[1] ? 1'b1 : lru_q[idx]);
  assign vdirty = w_valid[vway] && w_dirty[vway];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lru_q <= '0;
    else if (acc_hit) lru_q[idx] <= ~hit_way;
    else if (upd)     lru_q[idx] <= ~vic_q;
  end

  dcache_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .hit_i    (hit),
    .vdirty_i (vdirty),
    .vway_i   (vway),
    .st_o     (st),
    .stall_o  (stall_o),
    .vic_o    (vic_q)
  );

  assign base_word = upd ? mem_rdata_i : w_data[hit_way];

  dcache_lane u_lane (
    .word_i   (base_word),
    .wdata_i  (wdata_i),
    .size_i   (size_i),
    .off_i    (off),
    .load_o   (load_word),
    .merged_o (merged_word)
  );

  assign rdata_o     = load_word;
  assign mem_req_o   = (st == ST_WB) || (st == ST_FETCH);
  assign mem_we_o    = (st == ST_WB);
  assign mem_addr_o  = (st == ST_WB) ? {w_tag[vic_q], idx, {OFF_W{1'b0}}}
                                     : {tag, idx, {OFF_W{1'b0}}};
  assign mem_wdata_o = w_data[vic_q];
endmodule

// File: rtl/dcache2w_chk.sv
module dcache2w_chk
  import dcache_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stall_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-3:0] mem_wa,
  input logic [ADDR_W-3:0] core_wa,
  input dc_state_e         st
);
  p_wb_then_fetch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |=> (mem_req_o && !mem_we_o));

  p_wb_same_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_wa[IDX_W-1:0] == core_wa[IDX_W-1:0]));

  p_fetch_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> (mem_wa == core_wa));

  p_fetch_then_install_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> (!mem_req_o && stall_o));

  p_install_to_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_UPD) |=> (st == ST_IDLE));

  p_no_traffic_when_free_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_o |-> !mem_req_o);
endmodule

bind dcache2w dcache2w_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .stall_o   (stall_o),
  .mem_req_o (mem_req_o),
  .mem_we_o  (mem_we_o),
  .mem_wa    (mem_addr_o[ADDR_W-1:2]),
  .core_wa   (addr_i[ADDR_W-1:2]),
  .st        (st)
);

// File: tb/sim_dcache2w.sv
`timescale 1ns/1ps
module sim_dcache2w;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  size = 3'b010;
  logic [31:0] addr = '0, wdata = '0;
  logic [31:0] rdata, mem_addr, mem_wdata, mem_rdata;
  logic        stall, mem_req, mem_we;

  always #5 clk = ~clk;

  dcache2w u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .size_i(size),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .stall_o(stall),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  logic [31:0] mem  [4096];
  logic [31:0] refm [4096];
  int wr_cnt = 0, rd_cnt = 0;
  logic [31:0] last_wr = '0, last_rd = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (rst_ni && mem_req) begin
      if (mem_we) begin
        mem[mem_addr[13:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
        last_wr <= mem_addr;
      end else begin
        mem_rdata <= mem[mem_addr[13:2]];
        rd_cnt <= rd_cnt + 1;
        last_rd <= mem_addr;
      end
    end
  end

  function automatic logic [31:0] mk(int t, int s, int o);
    return (t << 10) | (s << 2) | o;
  endfunction

  function automatic logic [31:0] exp_load(logic [31:0] w, logic [2:0] sz, logic [1:0] o);
    logic [31:0] sh;
    sh = w >> (o * 8);
    case (sz)
      3'b000: return sh[7] ? (sh | 32'hFFFF_FF00) & 32'hFFFF_FFFF & {24'hFFFFFF, sh[7:0]} : {24'h0, sh[7:0]};
      3'b100: return {24'h0, sh[7:0]};
      3'b001: begin sh = w >> (o[1] * 16); return sh[15] ? {16'hFFFF, sh[15:0]} : {16'h0, sh[15:0]}; end
      3'b101: begin sh = w >> (o[1] * 16); return {16'h0, sh[15:0]}; end
      default: return w;
    endcase
  endfunction

  function automatic logic [31:0] exp_store(logic [31:0] w, logic [31:0] d, logic [2:0] sz, logic [1:0] o);
    logic [31:0] m;
    case (sz)
      3'b000: begin m = 32'hFF << (o * 8); return (w & ~m) | ((d & 32'hFF) << (o * 8)); end
      3'b001: begin m = 32'hFFFF << (o[1] * 16); return (w & ~m) | ((d & 32'hFFFF) << (o[1] * 16)); end
      default: return d;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(bit w, logic [2:0] sz, logic [31:0] a, logic [31:0] d,
                     output logic [31:0] rd, output int n);
    @(negedge clk);
    req = 1; we = w; size = sz; addr = a; wdata = d;
    n = 0;
    #1;
    while (stall && n < 20) begin
      n++;
      @(negedge clk);
      #1;
    end
    rd = rdata;
    if (w) refm[a[13:2]] = exp_store(refm[a[13:2]], d, sz, a[1:0]);
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic t_reset_state;
    @(negedge clk); #1;
    chk("R9 stall in reset", {31'b0, stall}, 32'h0);
    chk("R9 mem_req in reset", {31'b0, mem_req}, 32'h0);
    @(negedge clk); rst_ni = 1;
    @(negedge clk); #1;
    chk("R9 stall after reset", {31'b0, stall}, 32'h0);
    chk("R9 mem_req after reset", {31'b0, mem_req}, 32'h0);
  endtask

  task automatic t_clean_miss;
    logic [31:0] a, rd; int n, w0;
    a = mk(3, 5, 0);
    w0 = wr_cnt;
    acc(0, 3'b010, a, 0, rd, n);
    chk("R2 clean miss stall cycles", n, 3);
    chk("R2 miss data", rd, refm[a[13:2]]);
    chk("R2 fetch address", last_rd, {a[31:2], 2'b00});
    chk("R10 no write on clean miss", wr_cnt, w0);
    acc(0, 3'b010, a, 0, rd, n);
    chk("R1 hit stall cycles", n, 0);
    chk("R1 hit data", rd, refm[a[13:2]]);
  endtask

  task automatic t_lru;
    logic [31:0] rd; int n;
    acc(0, 3'b010, mk(0, 9, 0), 0, rd, n);
    acc(0, 3'b010, mk(1, 9, 0), 0, rd, n);
    chk("R4 second tag fills free way", n, 3);
    acc(0, 3'b010, mk(0, 9, 0), 0, rd, n);
    chk("R4 first tag still hits", n, 0);
    acc(0, 3'b010, mk(2, 9, 0), 0, rd, n);
    chk("R4 third tag miss", n, 3);
    acc(0, 3'b010, mk(0, 9, 0), 0, rd, n);
    chk("R4 recently used line kept", n, 0);
    chk("R4 kept data", rd, refm[mk(0, 9, 0) >> 2 & 12'hFFF]);
    acc(0, 3'b010, mk(1, 9, 0), 0, rd, n);
    chk("R4 least recent line evicted", n, 3);
  endtask

  task automatic t_write_hit;
    logic [31:0] a, rd, old; int n, w0;
    a = mk(0, 12, 0);
    acc(0, 3'b010, a, 0, rd, n);
    old = mem[a[13:2]];
    w0 = wr_cnt;
    acc(1, 3'b010, a, 32'hCAFE_0123, rd, n);
    chk("R5 store hit no stall", n, 0);
    @(negedge clk);
    chk("R5 no memory write", wr_cnt, w0);
    chk("R5 memory unchanged", mem[a[13:2]], old);
    acc(0, 3'b010, a, 0, rd, n);
    chk("R5 load sees store", rd, 32'hCAFE_0123);
  endtask

  task automatic t_dirty_evict;
    logic [31:0] d, rd, old; int n;
    d = mk(0, 20, 0);
    old = mem[d[13:2]];
    acc(1, 3'b010, d, 32'h1357_9BDF, rd, n);
    chk("R6 store miss stall cycles", n, 3);
    chk("R6 memory untouched after store miss", mem[d[13:2]], old);
    acc(0, 3'b010, mk(1, 20, 0), 0, rd, n);
    acc(0, 3'b010, mk(2, 20, 0), 0, rd, n);
    chk("R3 dirty miss stall cycles", n, 4);
    chk("R3 writeback address", last_wr, d);
    chk("R3 victim data in memory", mem[d[13:2]], 32'h1357_9BDF);
    chk("R3 new line data", rd, refm[mk(2, 20, 0) >> 2 & 12'hFFF]);
    acc(0, 3'b010, d, 0, rd, n);
    chk("R6 refetch after eviction", n, 3);
    chk("R6 merged store data", rd, 32'h1357_9BDF);
  endtask

  task automatic t_subword;
    logic [31:0] a, rd; int n;
    a = mk(0, 30, 0);
    acc(1, 3'b010, a, 32'h1122_3344, rd, n);
    acc(1, 3'b000, a | 1, 32'h0000_00AB, rd, n);
    acc(1, 3'b000, a | 3, 32'hFFFF_FF80, rd, n);
    acc(0, 3'b010, a, 0, rd, n);
    chk("R8 byte merges", rd, 32'h8022_AB44);
    acc(0, 3'b000, a | 3, 0, rd, n);
    chk("R7 signed byte off3", rd, 32'hFFFF_FF80);
    acc(0, 3'b100, a | 3, 0, rd, n);
    chk("R7 unsigned byte off3", rd, 32'h0000_0080);
    acc(0, 3'b000, a | 1, 0, rd, n);
    chk("R7 signed byte off1", rd, exp_load(refm[a[13:2]], 3'b000, 2'd1));
    acc(0, 3'b100, a, 0, rd, n);
    chk("R7 unsigned byte off0", rd, 32'h0000_0044);
    acc(1, 3'b001, a | 2, 32'h0000_8001, rd, n);
    acc(0, 3'b010, a, 0, rd, n);
    chk("R8 halfword merge", rd, 32'h8001_AB44);
    acc(0, 3'b001, a | 2, 0, rd, n);
    chk("R7 signed half", rd, 32'hFFFF_8001);
    acc(0, 3'b101, a | 2, 0, rd, n);
    chk("R7 unsigned half", rd, 32'h0000_8001);
    acc(0, 3'b001, a, 0, rd, n);
    chk("R7 signed half low", rd, 32'hFFFF_AB44);
  endtask

  task automatic t_mid_reset;
    logic [31:0] a, rd; int n;
    a = mk(1, 40, 0);
    acc(0, 3'b010, a, 0, rd, n);
    acc(0, 3'b010, a, 0, rd, n);
    chk("R1 hit before reset", n, 0);
    @(negedge clk); rst_ni = 0;
    @(negedge clk); rst_ni = 1;
    acc(0, 3'b010, a, 0, rd, n);
    chk("R9 line invalid after reset", n, 3);
    chk("R9 data after reset", rd, refm[a[13:2]]);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin
      mem[i]  = (i * 32'h0100_0193) ^ 32'h5A5A_0F0F;
      refm[i] = (i * 32'h0100_0193) ^ 32'h5A5A_0F0F;
    end
    mem_rdata = '0;
    t_reset_state();
    t_clean_miss();
    t_lru();
    t_write_hit();
    t_dirty_evict();
    t_subword();
    t_mid_reset();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule